// File: doc/BRIEF.md
# I2C Pin-Level to Byte-Transaction Bridge

This block sits between an I2C controller that drives raw SCL and SDA levels and a simple byte-level back end that stands in for the target devices. It watches the two pin levels, recognises START and STOP conditions, and assembles the bits clocked by the controller into bytes, most significant bit first. The first byte after a START names a 7-bit target and a direction. Later bytes are write data or, for a read, bytes fetched from the back end and shifted out onto SDA.

Every back-end request is a one-cycle strobe: a start strobe with address and direction, a send strobe with a data byte, or a receive strobe. Each is answered one cycle later by a response pulse that carries an accept/refuse flag and, for a receive, the data byte. The block also produces a nack strobe when the controller declines more read data, and an end strobe when an accepted transfer is closed. The SDA level it returns to the bus is the wired-AND of its own open-drain drive and the controller's level. Its own drive changes only while SCL is low.

The control state machine has these states. ST_IDLE waits for START. ST_WBIT7 to ST_WBIT0 collect bits, stepping by increment. ST_ACK_SLOT issues the request and then drives ACK or NACK. ST_RBIT7 to ST_RBIT0 present a read byte, also stepping by increment. ST_CTL_ACK samples the controller's acknowledge. ST_REFUSED is terminal until the next START.

The transitions are as follows. START goes from any state to ST_WBIT7. STOP goes from any state to ST_IDLE. ST_WBIT0 goes to ST_ACK_SLOT. ST_ACK_SLOT goes to ST_REFUSED on a refusal. Otherwise, on the ninth SCL rise, it goes to ST_RBIT7 for a read or to ST_WBIT7 for a write. ST_RBIT0 goes to ST_CTL_ACK. ST_CTL_ACK goes to ST_RBIT7 on a controller ACK and to ST_REFUSED on a controller NACK.

Top module: `i2c_pin_byte_bridge`

## Requirements
- R1: A synchronous reset puts the block in ST_IDLE with its SDA drive released (sda_o follows sda_i) and all back-end strobes low; this also holds when reset arrives in the middle of a read byte.
- R2: SDA falling while SCL is high is a START and begins collection of an address byte. SDA rising while SCL is high is a STOP: it returns to ST_IDLE and pulses be_end_o once, but only if an accepted target has not yet been ended.
- R3: Data bits are sampled on SCL rising edges and shifted in most significant bit first. During the eight bit periods of a controller-sent byte the block releases SDA.
- R4: The first byte after a START produces a be_start_o pulse. be_addr_o carries byte bits [7:1] and be_read_o carries byte bit 0 (1 = read). Each further byte in the write direction produces a be_send_o pulse with the byte on be_wdata_o.
- R5: When the back end accepts, the block drives SDA low (ACK) through the ninth clock. It then enters the read phase if bit 0 was 1, or collects the next write byte if bit 0 was 0.
- R6: When the back end refuses an address or a data byte, the block leaves SDA released in the ninth clock (NACK), pulses be_end_o and enters ST_REFUSED.
- R7: In the read phase the block pulses be_recv_o at the start of each byte and drives the received byte onto SDA most significant bit first. Each bit is set up while SCL is low and held for the following SCL high. SDA is released for the acknowledge clock.
- R8: After a read byte, SDA low at the ninth SCL rise (controller ACK) leads to the next be_recv_o. SDA high (controller NACK) pulses be_nack_o and enters ST_REFUSED.
- R9: In ST_IDLE and ST_REFUSED, SCL pulses cause no strobe and SDA stays released until a START.
- R10: A repeated START (no STOP before it) produces no be_end_o, and the next byte is again treated as an address byte.
- R11: sda_o is the AND of the block's own drive and sda_i.
- R12: The block's own SDA drive changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | SCL level driven by the controller |
| sda_i | input | 1 | SDA level driven by the controller |
| sda_o | output | 1 | SDA bus level: own drive AND controller level |
| be_start_o | output | 1 | One-cycle request to open a transfer |
| be_addr_o | output | 7 | Target address for be_start_o |
| be_read_o | output | 1 | Direction for be_start_o, 1 = read |
| be_send_o | output | 1 | One-cycle request to deliver a write byte |
| be_wdata_o | output | 8 | Write byte for be_send_o |
| be_recv_o | output | 1 | One-cycle request to fetch a read byte |
| be_nack_o | output | 1 | One-cycle notice that the controller declined read data |
| be_end_o | output | 1 | One-cycle notice that the accepted transfer is closed |
| be_resp_i | input | 1 | Response pulse, one cycle after a request |
| be_refuse_i | input | 1 | With be_resp_i: 1 = refused (NACK) |
| be_rdata_i | input | 8 | With be_resp_i after be_recv_o: read byte |

## Verification
On every cycle the assertions check four things. Only one request strobe is active at a time, and a start strobe appears only in the acknowledge slot. The drive stays released whenever the machine is idle or refused. A back-end refusal is followed at once by the end strobe and the refused state. The SDA drive also never moves while SCL has been high and is released right after reset. The directed scenarios are the only way to show that whole bytes travel correctly in both directions: the address and direction split, MSB-first order, ACK versus NACK at the ninth clock, and controller-NACK termination. They also show that a repeated START skips the end strobe and that an idle or refused bridge ignores clock pulses.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;

    // Bit states must stay consecutive: the machine steps by increment.
    typedef enum logic [4:0] {
        ST_IDLE     = 5'd0,
        ST_WBIT7    = 5'd1,
        ST_WBIT6    = 5'd2,
        ST_WBIT5    = 5'd3,
        ST_WBIT4    = 5'd4,
        ST_WBIT3    = 5'd5,
        ST_WBIT2    = 5'd6,
        ST_WBIT1    = 5'd7,
        ST_WBIT0    = 5'd8,
        ST_ACK_SLOT = 5'd9,
        ST_RBIT7    = 5'd10,
        ST_RBIT6    = 5'd11,
        ST_RBIT5    = 5'd12,
        ST_RBIT4    = 5'd13,
        ST_RBIT3    = 5'd14,
        ST_RBIT2    = 5'd15,
        ST_RBIT1    = 5'd16,
        ST_RBIT0    = 5'd17,
        ST_CTL_ACK  = 5'd18,
        ST_REFUSED  = 5'd19
    } state_t;

endpackage

// File: rtl/i2cbr_line_sense.sv
module i2cbr_line_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic start_ev,
    output logic stop_ev
);

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign scl_s = scl_i;
            assign sda_s = sda_i;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] scl_ff;
            logic [SYNC_STAGES-1:0] sda_ff;
            for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
                if (g == 0) begin : g_first
                    always_ff @(posedge clk) begin
                        if (rst) begin
                            scl_ff[g] <= 1'b1;
                            sda_ff[g] <= 1'b1;
                        end else begin
                            scl_ff[g] <= scl_i;
                            sda_ff[g] <= sda_i;
                        end
                    end
                end else begin : g_next
                    always_ff @(posedge clk) begin
                        if (rst) begin
                            scl_ff[g] <= 1'b1;
                            sda_ff[g] <= 1'b1;
                        end else begin
                            scl_ff[g] <= scl_ff[g-1];
                            sda_ff[g] <= sda_ff[g-1];
                        end
                    end
                end
            end
            assign scl_s = scl_ff[SYNC_STAGES-1];
            assign sda_s = sda_ff[SYNC_STAGES-1];
        end
    endgenerate

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cbr_ctrl.sv
module i2cbr_ctrl
    import i2cbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              sda_s,
    input  logic              be_resp_i,
    input  logic              be_refuse_i,
    input  logic [BYTE_W-1:0] be_rdata_i,
    output logic              be_start_o,
    output logic [ADDR_W-1:0] be_addr_o,
    output logic              be_read_o,
    output logic              be_send_o,
    output logic [BYTE_W-1:0] be_wdata_o,
    output logic              be_recv_o,
    output logic              be_nack_o,
    output logic              be_end_o,
    output logic              drv_next
);

    state_t            state_q, state_d;
    logic [BYTE_W-1:0] buf_q, buf_d;
    logic              tgt_ok_q, tgt_ok_d;
    logic              wait_q, wait_d;
    logic              drv_q, drv_d;
    logic              start_d, send_d, recv_d, nack_d, end_d;
    logic [ADDR_W-1:0] addr_d;
    logic              read_d;
    logic [BYTE_W-1:0] wdata_d;
    logic [BYTE_W-1:0] shifted;

    assign shifted  = {buf_q[BYTE_W-2:0], sda_s};
    assign drv_next = drv_q;

    // Next-state and next-output decisions
    always_comb begin
        state_d  = state_q;
        buf_d    = buf_q;
        tgt_ok_d = tgt_ok_q;
        wait_d   = wait_q;
        drv_d    = drv_q;
        start_d  = 1'b0;
        send_d   = 1'b0;
        recv_d   = 1'b0;
        nack_d   = 1'b0;
        end_d    = 1'b0;
        addr_d   = be_addr_o;
        read_d   = be_read_o;
        wdata_d  = be_wdata_o;

        if (stop_ev) begin
            state_d  = ST_IDLE;
            end_d    = tgt_ok_q;
            tgt_ok_d = 1'b0;
            wait_d   = 1'b0;
            drv_d    = 1'b1;
        end else if (start_ev) begin
            state_d  = ST_WBIT7;
            tgt_ok_d = 1'b0;
            wait_d   = 1'b0;
            drv_d    = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_REFUSED: begin
                end
                ST_WBIT7, ST_WBIT6, ST_WBIT5, ST_WBIT4,
                ST_WBIT3, ST_WBIT2, ST_WBIT1: begin
                    if (scl_rise) begin
                        buf_d   = shifted;
                        state_d = state_t'(state_q + 5'd1);
                        drv_d   = 1'b1;
                    end
                end
                ST_WBIT0: begin
                    if (scl_rise) begin
                        buf_d   = shifted;
                        state_d = ST_ACK_SLOT;
                        wait_d  = 1'b1;
                        if (!tgt_ok_q) begin
                            start_d  = 1'b1;
                            addr_d   = shifted[BYTE_W-1:1];
                            read_d   = shifted[0];
                            tgt_ok_d = 1'b1;
                        end else begin
                            send_d  = 1'b1;
                            wdata_d = shifted;
                        end
                    end
                end
                ST_ACK_SLOT: begin
                    if (wait_q) begin
                        if (be_resp_i) begin
                            wait_d = 1'b0;
                            if (be_refuse_i) begin
                                state_d  = ST_REFUSED;
                                end_d    = 1'b1;
                                tgt_ok_d = 1'b0;
                                drv_d    = 1'b1;
                            end else begin
                                drv_d = 1'b0;
                            end
                        end
                    end else if (scl_rise) begin
                        if (be_read_o) begin
                            state_d = ST_RBIT7;
                            recv_d  = 1'b1;
                            wait_d  = 1'b1;
                        end else begin
                            state_d = ST_WBIT7;
                            drv_d   = 1'b1;
                        end
                    end
                end
                ST_RBIT7: begin
                    if (wait_q) begin
                        if (be_resp_i) begin
                            wait_d = 1'b0;
                            buf_d  = be_rdata_i;
                            drv_d  = be_rdata_i[BYTE_W-1];
                        end
                    end else if (scl_rise) begin
                        buf_d   = buf_q << 1;
                        drv_d   = buf_q[BYTE_W-2];
                        state_d = ST_RBIT6;
                    end
                end
                ST_RBIT6, ST_RBIT5, ST_RBIT4, ST_RBIT3,
                ST_RBIT2, ST_RBIT1: begin
                    if (scl_rise) begin
                        buf_d   = buf_q << 1;
                        drv_d   = buf_q[BYTE_W-2];
                        state_d = state_t'(state_q + 5'd1);
                    end
                end
                ST_RBIT0: begin
                    if (scl_rise) begin
                        drv_d   = 1'b1;
                        state_d = ST_CTL_ACK;
                    end
                end
                ST_CTL_ACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            state_d = ST_REFUSED;
                            nack_d  = 1'b1;
                        end else begin
                            state_d = ST_RBIT7;
                            recv_d  = 1'b1;
                            wait_d  = 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    drv_d   = 1'b1;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            buf_q    <= '0;
            tgt_ok_q <= 1'b0;
            wait_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            buf_q    <= buf_d;
            tgt_ok_q <= tgt_ok_d;
            wait_q   <= wait_d;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q      <= 1'b1;
            be_start_o <= 1'b0;
            be_send_o  <= 1'b0;
            be_recv_o  <= 1'b0;
            be_nack_o  <= 1'b0;
            be_end_o   <= 1'b0;
            be_addr_o  <= '0;
            be_read_o  <= 1'b0;
            be_wdata_o <= '0;
        end else begin
            drv_q      <= drv_d;
            be_start_o <= start_d;
            be_send_o  <= send_d;
            be_recv_o  <= recv_d;
            be_nack_o  <= nack_d;
            be_end_o   <= end_d;
            be_addr_o  <= addr_d;
            be_read_o  <= read_d;
            be_wdata_o <= wdata_d;
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE || state_q == ST_REFUSED) |-> drv_q); // R9

    AST_START_IN_ACK_SLOT: assert property (@(posedge clk) disable iff (rst)
        be_start_o |-> (state_q == ST_ACK_SLOT)); // R4

    AST_END_AFTER_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACK_SLOT && wait_q && be_resp_i && be_refuse_i && !stop_ev && !start_ev)
        |=> (be_end_o && state_q == ST_REFUSED)); // R6

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
        $onehot0({be_start_o, be_send_o, be_recv_o, be_nack_o})); // R8

endmodule

// File: rtl/i2cbr_sda_drive.sv
module i2cbr_sda_drive (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic drv_next,
    input  logic sda_i,
    output logic sda_o
);

    logic sda_drv;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_drv <= 1'b1;
        end else if (!scl_s) begin
            sda_drv <= drv_next;
        end
    end

    assign sda_o = sda_drv & sda_i;

    AST_DRV_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($past(scl_s) && !$past(rst)) |-> $stable(sda_drv)); // R12

    AST_RELEASED_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> sda_drv); // R1

endmodule

// File: rtl/i2c_pin_byte_bridge.sv
module i2c_pin_byte_bridge
    import i2cbr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              be_start_o,
    output logic [ADDR_W-1:0] be_addr_o,
    output logic              be_read_o,
    output logic              be_send_o,
    output logic [BYTE_W-1:0] be_wdata_o,
    output logic              be_recv_o,
    output logic              be_nack_o,
    output logic              be_end_o,
    input  logic              be_resp_i,
    input  logic              be_refuse_i,
    input  logic [BYTE_W-1:0] be_rdata_i
);

    logic scl_s, sda_s, scl_rise, start_ev, stop_ev, drv_next;

    i2cbr_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2cbr_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .scl_rise    (scl_rise),
        .start_ev    (start_ev),
        .stop_ev     (stop_ev),
        .sda_s       (sda_s),
        .be_resp_i   (be_resp_i),
        .be_refuse_i (be_refuse_i),
        .be_rdata_i  (be_rdata_i),
        .be_start_o  (be_start_o),
        .be_addr_o   (be_addr_o),
        .be_read_o   (be_read_o),
        .be_send_o   (be_send_o),
        .be_wdata_o  (be_wdata_o),
        .be_recv_o   (be_recv_o),
        .be_nack_o   (be_nack_o),
        .be_end_o    (be_end_o),
        .drv_next    (drv_next)
    );

    i2cbr_sda_drive u_drive (
        .clk      (clk),
        .rst      (rst),
        .scl_s    (scl_s),
        .drv_next (drv_next),
        .sda_i    (sda_i),
        .sda_o    (sda_o)
    );

endmodule

// File: tb/i2c_pin_byte_bridge_tb_top.sv
`timescale 1ns/1ps
module i2c_pin_byte_bridge_tb_top;

    localparam int H = 8;
    localparam logic [6:0] MATCH_ADDR  = 7'h50;
    localparam logic [7:0] REFUSE_BYTE = 8'hEE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_c = 1'b1;
    logic sda_c = 1'b1;
    logic sda_o;
    logic be_start_o, be_read_o, be_send_o, be_recv_o, be_nack_o, be_end_o;
    logic [6:0] be_addr_o;
    logic [7:0] be_wdata_o;
    logic be_resp_i = 1'b0;
    logic be_refuse_i = 1'b0;
    logic [7:0] be_rdata_i = 8'h00;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int n_start = 0, n_send = 0, n_recv = 0, n_nack = 0, n_end = 0;
    logic [6:0] last_addr = '0;
    logic       last_rd   = 1'b0;
    logic [7:0] wr_log [0:15];
    logic [7:0] rd_bytes [0:3];

    always #4 clk = ~clk;

    i2c_pin_byte_bridge dut_i (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_c),
        .sda_i       (sda_c),
        .sda_o       (sda_o),
        .be_start_o  (be_start_o),
        .be_addr_o   (be_addr_o),
        .be_read_o   (be_read_o),
        .be_send_o   (be_send_o),
        .be_wdata_o  (be_wdata_o),
        .be_recv_o   (be_recv_o),
        .be_nack_o   (be_nack_o),
        .be_end_o    (be_end_o),
        .be_resp_i   (be_resp_i),
        .be_refuse_i (be_refuse_i),
        .be_rdata_i  (be_rdata_i)
    );

    // Back-end model: registered one-cycle response
    always @(posedge clk) begin
        be_resp_i   <= 1'b0;
        be_refuse_i <= 1'b0;
        if (be_start_o) begin
            be_resp_i   <= 1'b1;
            be_refuse_i <= (be_addr_o != MATCH_ADDR);
            last_addr   <= be_addr_o;
            last_rd     <= be_read_o;
            n_start     <= n_start + 1;
        end
        if (be_send_o) begin
            be_resp_i      <= 1'b1;
            be_refuse_i    <= (be_wdata_o == REFUSE_BYTE);
            wr_log[n_send[3:0]] <= be_wdata_o;
            n_send         <= n_send + 1;
        end
        if (be_recv_o) begin
            be_resp_i  <= 1'b1;
            be_rdata_i <= rd_bytes[n_recv[1:0]];
            n_recv     <= n_recv + 1;
        end
        if (be_nack_o) n_nack <= n_nack + 1;
        if (be_end_o)  n_end  <= n_end + 1;
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic gen_start();
        sda_c = 1'b1; waitc(H);
        scl_c = 1'b1; waitc(H);
        sda_c = 1'b0; waitc(H);
        scl_c = 1'b0; waitc(H);
    endtask

    task automatic gen_stop();
        scl_c = 1'b0; sda_c = 1'b0; waitc(H);
        scl_c = 1'b1; waitc(H);
        sda_c = 1'b1; waitc(H);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_c = b;     waitc(H);
        scl_c = 1'b1;  waitc(H/2);
        seen = sda_o;  waitc(H/2);
        scl_c = 1'b0;
    endtask

    // Returns bus level seen in the acknowledge clock (0 = ACK)
    task automatic write_byte(input logic [7:0] b, input string req, output logic ack_seen);
        logic s;
        int rel_bad = 0;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i], s);
            if (s !== b[i]) rel_bad++;
        end
        clk_bit(1'b1, ack_seen);
        chk(req, rel_bad, 0);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] got);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            got[i] = s;
        end
        clk_bit(!give_ack, s);
    endtask

    task automatic t_reset();
        chk("R1 sda released after reset", {31'd0, sda_o}, 1);
        chk("R1 no strobes after reset", n_start + n_send + n_recv + n_nack + n_end, 0);
    endtask

    task automatic t_write();
        logic a;
        gen_start();
        write_byte(8'hA0, "R3 release during address bits", a);
        chk("R5 address ack", {31'd0, a}, 0);
        chk("R4 start strobe count", n_start, 1);
        chk("R4 target address", {25'd0, last_addr}, 32'h50);
        chk("R4 write direction", {31'd0, last_rd}, 0);
        write_byte(8'h3C, "R3 release during data bits", a);
        chk("R5 data ack 1", {31'd0, a}, 0);
        write_byte(8'hA5, "R3 release during data bits", a);
        chk("R5 data ack 2", {31'd0, a}, 0);
        chk("R4 send strobe count", n_send, 2);
        chk("R3 first byte msb first", {24'd0, wr_log[0]}, 32'h3C);
        chk("R3 second byte msb first", {24'd0, wr_log[1]}, 32'hA5);
        gen_stop();
        chk("R2 stop ends accepted transfer", n_end, 1);
    endtask

    task automatic t_addr_refuse();
        logic a;
        gen_start();
        write_byte(8'h44, "R3 release during address bits", a);
        chk("R6 address refused gives nack", {31'd0, a}, 1);
        chk("R6 end strobe on refusal", n_end, 2);
        write_byte(8'hFF, "R9 sda released while refused", a);
        chk("R9 no ack while refused", {31'd0, a}, 1);
        chk("R9 no start strobe while refused", n_start, 2);
        chk("R9 no send strobe while refused", n_send, 2);
        gen_stop();
        chk("R2 stop after refusal gives no end", n_end, 2);
        write_byte(8'hFF, "R9 sda released while idle", a);
        chk("R9 idle ignores clocks", n_start + n_send + n_recv, 32'd4);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] got;
        gen_start();
        write_byte(8'hA1, "R3 release during address bits", a);
        chk("R5 read address ack", {31'd0, a}, 0);
        chk("R4 read direction", {31'd0, last_rd}, 1);
        read_byte(1'b1, got);
        chk("R7 first read byte", {24'd0, got}, 32'h96);
        read_byte(1'b0, got);
        chk("R7 second read byte", {24'd0, got}, 32'h5A);
        chk("R8 recv strobes", n_recv, 2);
        chk("R8 controller nack strobe", n_nack, 1);
        write_byte(8'h00, "R9 refused ignores clocks", a);
        chk("R9 no recv after controller nack", n_recv, 2);
        gen_stop();
        chk("R2 stop after read ends transfer", n_end, 3);
    endtask

    task automatic t_data_refuse();
        logic a;
        gen_start();
        write_byte(8'hA0, "R3 release during address bits", a);
        chk("R5 address ack", {31'd0, a}, 0);
        write_byte(REFUSE_BYTE, "R3 release during data bits", a);
        chk("R6 data refused gives nack", {31'd0, a}, 1);
        chk("R6 end strobe on data refusal", n_end, 4);
        gen_stop();
        chk("R2 no second end", n_end, 4);
    endtask

    task automatic t_rep_start();
        logic a;
        logic [7:0] got;
        gen_start();
        write_byte(8'hA0, "R3 release during address bits", a);
        write_byte(8'h11, "R3 release during data bits", a);
        chk("R5 ack before repeated start", {31'd0, a}, 0);
        gen_start();
        chk("R10 repeated start gives no end", n_end, 4);
        write_byte(8'hA1, "R3 release during address bits", a);
        chk("R10 new start strobe", n_start, 6);
        chk("R10 new direction read", {31'd0, last_rd}, 1);
        read_byte(1'b0, got);
        chk("R7 read byte after repeated start", {24'd0, got}, 32'hC3);
        gen_stop();
        chk("R2 stop after repeated start", n_end, 5);
    endtask

    task automatic t_reset_mid();
        logic a;
        gen_start();
        write_byte(8'hA1, "R3 release during address bits", a);
        waitc(H);
        chk("R11 bus low from own zero bit", {31'd0, sda_o}, 0);
        rst = 1'b1; waitc(2);
        rst = 1'b0; waitc(1);
        chk("R1 reset mid-read releases sda", {31'd0, sda_o}, 1);
        sda_c = 1'b0; waitc(1);
        chk("R11 bus follows controller low", {31'd0, sda_o}, 0);
        scl_c = 1'b1; waitc(H);
        sda_c = 1'b1; waitc(H);
        chk("R1 no end strobe after reset", n_end, 5);
    endtask

    initial begin
        rd_bytes[0] = 8'h96;
        rd_bytes[1] = 8'h5A;
        rd_bytes[2] = 8'hC3;
        rd_bytes[3] = 8'h00;
        waitc(4);
        rst = 1'b0;
        waitc(4);
        t_reset();
        t_write();
        t_addr_refuse();
        t_read();
        t_data_refuse();
        t_rep_start();
        t_reset_mid();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule